// File: doc/BRIEF.md
# Multi-Error ECC Correction Sequencer

This block drives the correction phase of a four-error-per-sector code engine that protects 512-byte sectors. After a sector has been read, the host pulses a start input with the eight 10-bit check words that were stored alongside the sector. The sequencer feeds those words, one per cycle, into an external syndrome unit. It then examines the syndrome. A clean sector finishes at once with no corrections.

When the syndrome shows errors, the sequencer clears any stale locator result and starts the external algebraic locator. It then tracks the locator's status field. The locator shows a misleading "complete" code for a short time after it is started, so the sequencer first waits for a working code, bounded by a timeout of 100 µs of clock cycles. It then waits for a real completion. On completion it reads up to four address/value pairs. It turns each reversed address into a byte offset within the sector and issues an XOR write command to the sector buffer for each offset that falls inside the sector. A single-cycle done pulse reports how many corrections were applied and whether the sector could not be corrected.

Top module: `ecc_fix_seq`

## Requirements
- R1: After an accepted start, the eight check words appear on `load_d_o` on eight consecutive cycles with `load_v_o` high, in the order index 7, 6, … 0. Index k is `codes_i[10k+9:10k]`.
- R2: Each 32-bit syndrome word is examined only in bits 25:16 and 9:0. If all four words are zero there, the sequencer ends with done, a count of 0 and fail low, and it issues neither a clear nor a locator start.
- R3: When the syndrome is nonzero, `addr_clr_o` pulses exactly one cycle before `calc_start_o` pulses.
- R4: The status code is `status_i[11:8]`. Code 0 ends the run with count 0 and fail low. Code 1 ends it with fail high. In both cases `release_o` pulses in the same cycle as done. It never pulses otherwise.
- R5: After the locator start, codes 2 and 3 are not taken as completion until a code of 4 or more has been seen, or until CLK_MHZ*100 cycles have passed in the wait. Codes of 4 or more keep the sequencer polling.
- R6: On completion (code 2 or 3), the number of errors processed is 1 + `status_i[17:16]`.
- R7: Errors 0 and 1 take their address and value from the first register pair, and errors 2 and 3 from the second pair. Even-numbered errors use bits 15:0 and odd-numbered errors use bits 31:16.
- R8: The raw address is the low 10 bits of its half-word. The offset is 519 minus that value. An XOR write (`fix_we_o`, `fix_addr_o` = offset, `fix_mask_o` = low byte of the value half) is issued only when the offset lies in 0..511. Otherwise the error is skipped.
- R9: `done_o` is a one-cycle pulse. `fix_cnt_o` equals the number of XOR writes issued in that run, and `fail_o` is high only with done.
- R10: A start request while `busy_o` is high is ignored. It causes no extra loads, no new check words and no second done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only when idle |
| codes_i | input | NCODE*CW | Stored check words, index k at bits 10k+9:10k |
| load_v_o | output | 1 | Check word valid toward the syndrome unit |
| load_d_o | output | CW | Check word toward the syndrome unit |
| synd_i | input | 128 | Four 32-bit syndrome words |
| addr_clr_o | output | 1 | Dummy-read strobe clearing the old locator result |
| calc_start_o | output | 1 | Locator start strobe |
| status_i | input | 32 | Locator status: code in 11:8, error count minus one in 17:16 |
| release_o | output | 1 | Dummy-read strobe releasing the locator on code 0 or 1 |
| err_add1_i | input | 32 | Address pair for errors 0 (low half) and 1 (high half) |
| err_add2_i | input | 32 | Address pair for errors 2 (low half) and 3 (high half) |
| err_val1_i | input | 32 | Value pair for errors 0 and 1 |
| err_val2_i | input | 32 | Value pair for errors 2 and 3 |
| fix_we_o | output | 1 | XOR write command to the sector buffer |
| fix_addr_o | output | OFF_W | Byte offset in the sector |
| fix_mask_o | output | 8 | Byte to XOR into the buffer |
| busy_o | output | 1 | Sequencer active |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fix_cnt_o | output | 3 | Corrections applied, valid with done |
| fail_o | output | 1 | Uncorrectable sector, valid with done |

## Verification
On every cycle, the assertions check these behaviours:
- a locator start is always preceded by a clear pulse;
- strobes toward the external units never overlap;
- the check-word burst stays unbroken until its last word;
- the wait never moves to polling without a working code or an expired timer;
- done is a one-cycle pulse that carries any release or fail.

Only the bench scenarios can show the value-level behaviour:
- the exact 7-to-0 load order;
- the masking of the syndrome;
- how the four errors map onto the register pairs and halves;
- the reversal against 519 across all 1024 raw addresses;
- that the count matches the writes issued;
- that a timed-out wait still completes;
- that a start during a run is dropped.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SYND, S_CLR, S_WAIT, S_POLL, S_FIX
  } seq_state_t;

  localparam int unsigned STAT_LSB  = 8;
  localparam int unsigned CNT_LSB   = 16;
  localparam int unsigned SYN_WORDS = 4;
  localparam logic [31:0] SYN_MASK  = 32'h03ff_03ff;
endpackage

// File: rtl/ecc_fix_loader.sv
module ecc_fix_loader #(
  parameter int CW    = 10,
  parameter int NCODE = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go_i,
  input  logic [NCODE*CW-1:0] codes_i,
  output logic                load_v_o,
  output logic [CW-1:0]       load_d_o,
  output logic                last_o
);
  localparam int IW = (NCODE > 1) ? $clog2(NCODE) : 1;

  logic [NCODE*CW-1:0] shreg;
  logic [IW-1:0]       left;
  logic                act;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      left     <= '0;
      act      <= 1'b0;
      load_v_o <= 1'b0;
      load_d_o <= '0;
      last_o   <= 1'b0;
    end else if (go_i) begin
      shreg    <= codes_i;
      left     <= IW'(NCODE - 1);
      act      <= 1'b1;
      load_v_o <= 1'b0;
      last_o   <= 1'b0;
    end else if (act) begin
      load_v_o <= 1'b1;
      load_d_o <= shreg[NCODE*CW-1 -: CW];
      shreg    <= shreg << CW;
      last_o   <= (left == '0);
      if (left == '0) act <= 1'b0;
      else            left <= left - 1'b1;
    end else begin
      load_v_o <= 1'b0;
      last_o   <= 1'b0;
    end
  end

  AST_LOAD_CONTIG: assert property (@(posedge clk) disable iff (rst)
    (load_v_o && !last_o) |=> load_v_o); // R1
endmodule

// File: rtl/ecc_fix_timer.sv
module ecc_fix_timer #(
  parameter int LIMIT = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  assign expired_o = (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr_i)              cnt <= '0;
    else if (run_i && !expired_o)  cnt <= cnt + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < TW'(LIMIT)); // R5
endmodule

// File: rtl/ecc_fix_locate.sv
module ecc_fix_locate #(
  parameter int SECTOR = 512,
  parameter int AW     = 10
) (
  input  logic [1:0]                  idx_i,
  input  logic [31:0]                 add1_i,
  input  logic [31:0]                 add2_i,
  input  logic [31:0]                 val1_i,
  input  logic [31:0]                 val2_i,
  output logic [$clog2(SECTOR)-1:0]   off_o,
  output logic [7:0]                  mask_o,
  output logic                        hit_o
);
  localparam int OFF_W = $clog2(SECTOR);
  localparam int DW    = AW + 2;
  localparam int BASE  = SECTOR + 7;

  logic [31:0]   aword, vword;
  logic [15:0]   ahalf, vhalf;
  logic [DW-1:0] diff;

  always_comb begin
    aword  = idx_i[1] ? add2_i : add1_i;
    vword  = idx_i[1] ? val2_i : val1_i;
    ahalf  = idx_i[0] ? aword[31:16] : aword[15:0];
    vhalf  = idx_i[0] ? vword[31:16] : vword[15:0];
    diff   = DW'(BASE) - {2'b00, ahalf[AW-1:0]};
    hit_o  = (diff < DW'(SECTOR));
    off_o  = diff[OFF_W-1:0];
    mask_o = vhalf[7:0];
  end
endmodule

// File: rtl/ecc_fix_seq.sv
module ecc_fix_seq
  import ecc_fix_pkg::*;
#(
  parameter int CW      = 10,
  parameter int NCODE   = 8,
  parameter int SECTOR  = 512,
  parameter int CLK_MHZ = 100,
  localparam int OFF_W  = $clog2(SECTOR)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [NCODE*CW-1:0] codes_i,
  output logic                load_v_o,
  output logic [CW-1:0]       load_d_o,
  input  logic [127:0]        synd_i,
  output logic                addr_clr_o,
  output logic                calc_start_o,
  input  logic [31:0]         status_i,
  output logic                release_o,
  input  logic [31:0]         err_add1_i,
  input  logic [31:0]         err_add2_i,
  input  logic [31:0]         err_val1_i,
  input  logic [31:0]         err_val2_i,
  output logic                fix_we_o,
  output logic [OFF_W-1:0]    fix_addr_o,
  output logic [7:0]          fix_mask_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [2:0]          fix_cnt_o,
  output logic                fail_o
);
  localparam int WAIT_LIMIT = CLK_MHZ * 100;

  seq_state_t        state;
  logic              ld_last;
  logic              tmr_exp;
  logic              synd_nz;
  logic [3:0]        stat_code;
  logic              stat_busy;
  logic [1:0]        idx, nerr_m1;
  logic [2:0]        acc;
  logic [OFF_W-1:0]  loc_off;
  logic [7:0]        loc_mask;
  logic              loc_hit;

  assign busy_o    = (state != S_IDLE);
  assign stat_code = status_i[STAT_LSB +: 4];
  assign stat_busy = (stat_code >= 4'd4);

  always_comb begin
    synd_nz = 1'b0;
    for (int w = 0; w < SYN_WORDS; w++)
      synd_nz = synd_nz | (|(synd_i[w*32 +: 32] & SYN_MASK));
  end

  ecc_fix_loader #(.CW(CW), .NCODE(NCODE)) loader_i (
    .clk      (clk),
    .rst      (rst),
    .go_i     ((state == S_IDLE) && start_i),
    .codes_i  (codes_i),
    .load_v_o (load_v_o),
    .load_d_o (load_d_o),
    .last_o   (ld_last)
  );

  ecc_fix_timer #(.LIMIT(WAIT_LIMIT)) timer_i (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (state == S_CLR),
    .run_i     (state == S_WAIT),
    .expired_o (tmr_exp)
  );

  ecc_fix_locate #(.SECTOR(SECTOR), .AW(CW)) locate_i (
    .idx_i  (idx),
    .add1_i (err_add1_i),
    .add2_i (err_add2_i),
    .val1_i (err_val1_i),
    .val2_i (err_val2_i),
    .off_o  (loc_off),
    .mask_o (loc_mask),
    .hit_o  (loc_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      addr_clr_o   <= 1'b0;
      calc_start_o <= 1'b0;
      release_o    <= 1'b0;
      fix_we_o     <= 1'b0;
      fix_addr_o   <= '0;
      fix_mask_o   <= '0;
      done_o       <= 1'b0;
      fix_cnt_o    <= '0;
      fail_o       <= 1'b0;
      idx          <= '0;
      nerr_m1      <= '0;
      acc          <= '0;
    end else begin
      addr_clr_o   <= 1'b0;
      calc_start_o <= 1'b0;
      release_o    <= 1'b0;
      fix_we_o     <= 1'b0;
      done_o       <= 1'b0;
      fail_o       <= 1'b0;
      unique case (state)
        S_IDLE: if (start_i) state <= S_LOAD;
        S_LOAD: if (ld_last) state <= S_SYND;
        S_SYND: begin
          if (!synd_nz) begin
            done_o    <= 1'b1;
            fix_cnt_o <= '0;
            state     <= S_IDLE;
          end else begin
            addr_clr_o <= 1'b1;
            state      <= S_CLR;
          end
        end
        S_CLR: begin
          calc_start_o <= 1'b1;
          state        <= S_WAIT;
        end
        S_WAIT: if (stat_busy || tmr_exp) state <= S_POLL;
        S_POLL: begin
          if (stat_code == 4'd0 || stat_code == 4'd1) begin
            release_o <= 1'b1;
            done_o    <= 1'b1;
            fail_o    <= stat_code[0];
            fix_cnt_o <= '0;
            state     <= S_IDLE;
          end else if (stat_code == 4'd2 || stat_code == 4'd3) begin
            nerr_m1 <= status_i[CNT_LSB +: 2];
            idx     <= '0;
            acc     <= '0;
            state   <= S_FIX;
          end
        end
        S_FIX: begin
          fix_we_o   <= loc_hit;
          fix_addr_o <= loc_off;
          fix_mask_o <= loc_mask;
          if (idx == nerr_m1) begin
            done_o    <= 1'b1;
            fix_cnt_o <= acc + {2'b00, loc_hit};
            state     <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
            acc <= acc + {2'b00, loc_hit};
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_CLR_LEADS_START: assert property (@(posedge clk) disable iff (rst)
    calc_start_o |-> $past(addr_clr_o)); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load_v_o, addr_clr_o, calc_start_o, fix_we_o})); // R3
  AST_NO_EARLY_POLL: assert property (@(posedge clk) disable iff (rst)
    (state == S_POLL && $past(state) == S_WAIT) |->
      ($past(status_i[STAT_LSB +: 4]) >= 4'd4 || $past(tmr_exp))); // R5
  AST_REL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    release_o |-> done_o); // R4
  AST_FAIL_NO_FIX: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (done_o && fix_cnt_o == 3'd0)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> fix_cnt_o <= 3'd4); // R6
endmodule

// File: tb/ecc_fix_seq_tb.sv
module ecc_fix_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ        = 1;
  localparam int LIMIT      = MHZ * 100;

  logic         clk = 1'b0, rst = 1'b1, start_i = 1'b0;
  logic [79:0]  codes_i = '0;
  logic         load_v_o, addr_clr_o, calc_start_o, release_o;
  logic [9:0]   load_d_o;
  logic [127:0] synd_i = '0;
  logic [31:0]  status_i, add1, add2, val1, val2;
  logic         fix_we_o, busy_o, done_o, fail_o;
  logic [8:0]   fix_addr_o;
  logic [7:0]   fix_mask_o;
  logic [2:0]   fix_cnt_o;

  ecc_fix_seq #(.CLK_MHZ(MHZ)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .codes_i(codes_i),
    .load_v_o(load_v_o), .load_d_o(load_d_o), .synd_i(synd_i),
    .addr_clr_o(addr_clr_o), .calc_start_o(calc_start_o), .status_i(status_i),
    .release_o(release_o), .err_add1_i(add1), .err_add2_i(add2),
    .err_val1_i(val1), .err_val2_i(val2), .fix_we_o(fix_we_o),
    .fix_addr_o(fix_addr_o), .fix_mask_o(fix_mask_o), .busy_o(busy_o),
    .done_o(done_o), .fix_cnt_o(fix_cnt_o), .fail_o(fail_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int ph = 0, hold3 = 2, work = 3, fin = 2, nerr_m1 = 0;
  int ea[4], ev[4], cw[8];
  int ld[16], n_ld, clr_at, st_at, done_at, nw, wa[8], wm[8];
  int got_cnt, got_fail, got_rel, extra;

  always @(posedge clk) begin
    if (calc_start_o) ph <= 1;
    else if (ph != 0) ph <= ph + 1;
  end

  logic [3:0] scode;
  assign scode = (ph == 0 || ph <= hold3) ? 4'd3 :
                 (ph <= hold3 + work) ? 4'd5 : 4'(fin);
  assign status_i = {14'd0, 2'(nerr_m1), 4'd0, scode, 8'd0};
  assign add1 = {6'h3f, 10'(ea[1]), 6'h3f, 10'(ea[0])};
  assign add2 = {6'h3f, 10'(ea[3]), 6'h3f, 10'(ea[2])};
  assign val1 = {16'(ev[1]), 16'(ev[0])};
  assign val2 = {16'(ev[3]), 16'(ev[2])};

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors++;
      $display("FAIL R9 watchdog: actual cycles %0d expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_codes(input int seed);
    for (int k = 0; k < 8; k++) begin
      cw[k] = (k * 97 + seed * 13 + 5) & 1023;
      codes_i[k*10 +: 10] = 10'(cw[k]);
    end
  endtask

  task automatic run(input bit poke_busy);
    int t = 0;
    n_ld = 0; clr_at = -1; st_at = -1; done_at = -1; nw = 0; extra = 0;
    got_rel = 0;
    @(negedge clk); start_i = 1'b1;
    while (done_at < 0 && t < 3000) begin
      @(negedge clk);
      if (t == 0) start_i = 1'b0;
      if (poke_busy && t == 4) begin start_i = 1'b1; codes_i = ~codes_i; end
      if (poke_busy && t == 5) start_i = 1'b0;
      if (load_v_o && n_ld < 16) begin ld[n_ld] = int'(load_d_o); n_ld++; end
      if (addr_clr_o) clr_at = t;
      if (calc_start_o) st_at = t;
      if (fix_we_o && nw < 8) begin wa[nw] = int'(fix_addr_o); wm[nw] = int'(fix_mask_o); nw++; end
      if (done_o) begin
        done_at = t; got_cnt = int'(fix_cnt_o); got_fail = int'(fail_o);
        got_rel = int'(release_o);
      end
      t++;
    end
    if (poke_busy)
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        if (load_v_o || done_o) extra++;
      end
  endtask

  task automatic judge(input bit zero, input bit to_mode);
    int ew[8], em[8], ne;
    chk(done_at >= 0, "R9 done seen", done_at, 1);
    chk(n_ld == 8, "R1 load count", n_ld, 8);
    for (int k = 0; k < 8; k++)
      chk(ld[k] == cw[7-k], "R1 load order", ld[k], cw[7-k]);
    if (zero) begin
      chk(clr_at < 0 && st_at < 0, "R2 no locator start", st_at, -1);
      chk(got_cnt == 0 && got_fail == 0 && nw == 0, "R2 clean result", got_cnt, 0);
      return;
    end
    chk(st_at >= 0 && clr_at == st_at - 1, "R3 clear leads start", clr_at, st_at - 1);
    if (to_mode)
      chk(done_at - st_at >= LIMIT && done_at - st_at < hold3, "R5 timeout", done_at - st_at, LIMIT);
    else
      chk(done_at - st_at > hold3 + work, "R5 waited for working", done_at - st_at, hold3 + work + 1);
    if (fin < 2) begin
      chk(got_rel == 1, "R4 release", got_rel, 1);
      chk(got_fail == fin && got_cnt == 0 && nw == 0, "R4 end code", got_fail, fin);
      return;
    end
    chk(got_rel == 0 && got_fail == 0, "R4 no release on completion", got_rel, 0);
    ne = 0;
    for (int i = 0; i <= nerr_m1; i++) begin
      int off = 519 - (ea[i] & 1023);
      if (off >= 0 && off < 512) begin ew[ne] = off; em[ne] = ev[i] & 255; ne++; end
    end
    chk(nw == ne, "R6 write count", nw, ne);
    chk(got_cnt == ne, "R9 corrected count", got_cnt, ne);
    for (int i = 0; i < ne && i < nw; i++) begin
      chk(wa[i] == ew[i], "R8 offset", wa[i], ew[i]);
      chk(wm[i] == em[i], "R7 value", wm[i], em[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done_o && !busy_o && !fix_we_o && !fail_o, "R9 reset state", int'(busy_o), 0);

    // R2: all-zero syndrome, then bits only outside the masked fields
    set_codes(1); synd_i = '0; run(1'b0); judge(1'b1, 1'b0);
    set_codes(2); synd_i = {4{32'hfc00_fc00}}; run(1'b0); judge(1'b1, 1'b0);

    synd_i = 128'h0 | (128'h1 << 80);
    // R4: decoder reports no error, then too many errors
    hold3 = 2; work = 3;
    fin = 0; set_codes(3); run(1'b0); judge(1'b0, 1'b0);
    fin = 1; set_codes(4); run(1'b0); judge(1'b0, 1'b0);

    // R6 R7: each error count with both completion codes
    for (int f = 2; f <= 3; f++)
      for (int n = 0; n < 4; n++) begin
        fin = f; nerr_m1 = n;
        ea[0] = 19; ea[1] = 300; ea[2] = 510; ea[3] = 8;
        ev[0] = 16'h1a5; ev[1] = 16'h2c3; ev[2] = 16'h37e; ev[3] = 16'h401;
        set_codes(10 + n + f); run(1'b0); judge(1'b0, 1'b0);
      end

    // R5: status never shows working; wait must time out then complete
    hold3 = LIMIT + 60; work = 0; fin = 2; nerr_m1 = 1;
    set_codes(20); run(1'b0); judge(1'b0, 1'b1);

    // R10: second start during a run is dropped
    hold3 = 2; work = 3; fin = 3; nerr_m1 = 0;
    set_codes(21); run(1'b1); judge(1'b0, 1'b0);
    chk(extra == 0, "R10 busy start ignored", extra, 0);

    // R8: every raw address value, single error
    hold3 = 1; work = 1; fin = 2; nerr_m1 = 0;
    for (int r = 0; r < 1024; r++) begin
      ea[0] = r; ev[0] = ((r * 7 + 3) & 255) | 256;
      set_codes(r); run(1'b0); judge(1'b0, 1'b0);
    end

    summary();
    $finish;
  end
endmodule